// File: doc/BRIEF.md
# Inter-Processor Mailbox with Hardware Locks

This block passes short messages between processors that share one register port. It holds four message slots. Each slot pairs a command word with a data word and carries a pending flag. The sender writes the data word first and then the command word. The command write raises the slot's pending flag. If the receiver has enabled that slot, the raised flag drives the slot's interrupt line. The receiver reads the words and then clears the flag by writing a one to it.

Beside the slots sits a bank of 32 single-bit locks with test-and-set behaviour. A read of a lock returns its value from before the read and leaves the lock held. A write of zero frees the lock. Software uses the locks to mark that the mailbox, or a part of it, is in use.

The port is word addressed, and each access completes in one cycle. Register decode sorts every address into one of six kinds: command, data, flag, enable, lock and unmapped. The address map is as follows. Command words of slots 0 to 3 sit at addresses 0 to 3. Data words sit at 4 to 7. The flag register is at 8 and the enable register at 9. Locks 0 to 31 sit at 32 to 63. Every other address is unmapped.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset all command words, data words, flags, enables and locks are zero, `irq` is zero and `rd_data` is zero.
- R2: A write to address 4+i stores the data word of slot i. A read of that address returns the word. A data write leaves every flag unchanged.
- R3: A write to address i (i = 0..3) stores the command word of slot i and sets flag i.
- R4: `irq[i]` is 1 exactly when flag i and enable i are both 1. It follows register changes in the cycle after the write.
- R5: In a write to address 8, bit i (i = 0..3) set to 1 clears flag i. A 0 in that bit leaves flag i unchanged. A read of address 8 returns the flags in bits 3:0 and zeros elsewhere.
- R6: In a write to address 8, bit 4+i set to 1 sets flag i. If bit i and bit 4+i are both 1 in the same write, flag i ends up set.
- R7: A read of address 32+k returns lock k's previous value in bit 0, with zeros above, and leaves lock k at 1.
- R8: A write to address 32+k with bit 0 equal to 0 frees lock k. With bit 0 equal to 1 the write has no effect.
- R9: Read data appears on `rd_data` at the clock edge that accepts the read. It holds until the next read. Reads of unmapped addresses return zero, and writes to them change nothing.
- R10: A write to address 9 loads the slot enables from bits 3:0. A read of address 9 returns them in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 6 | Word address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 4 | Per-slot interrupt, flag AND enable |

## Verification
Two operations can hit the same flag in one cycle: clearing it and raising it. Both happen when one flag-register write carries the clear bit and the set bit for the same slot. The bench sends such writes on purpose, and it also produces them by chance in a pseudo-random phase. The behavioural model lets the set win, and the flag read-back and `irq` must agree with the model on the next cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Kind of register selected by an address on the port
    typedef enum logic [2:0] {
        RG_NONE,
        RG_CMD,
        RG_DATA,
        RG_FLAG,
        RG_EN,
        RG_LOCK
    } reg_kind_e;

endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              data_we,
    input  logic              en_we,
    input  logic              flag_clr,
    input  logic              flag_set,
    input  logic [DATA_W-1:0] wdata,
    input  logic              en_wdata,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] data_q,
    output logic              flag_q,
    output logic              en_q,
    output logic              irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
            flag_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            if (cmd_we)  cmd_q  <= wdata;
            if (data_we) data_q <= wdata;
            if (en_we)   en_q   <= en_wdata;
            // raising has priority over clearing
            if (cmd_we || flag_set) flag_q <= 1'b1;
            else if (flag_clr)      flag_q <= 1'b0;
        end
    end

    assign irq = flag_q & en_q;

    // R3
    cmd_raises_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> flag_q);

    // R6
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set && flag_clr) |=> flag_q);

    // R5
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !flag_set && !cmd_we) |=> !flag_q);

    // R2
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_clr && !flag_set && !cmd_we) |=> $stable(flag_q));

endmodule

// File: rtl/mbox_lock_bank.sv
module mbox_lock_bank #(
    parameter int NUM_LOCKS = 32,
    localparam int IDX_W = $clog2(NUM_LOCKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 wbit,
    output logic [NUM_LOCKS-1:0] locks
);

    for (genvar k = 0; k < NUM_LOCKS; k++) begin : g_lock
        logic hit;
        assign hit = (idx == IDX_W'(k));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     locks[k] <= 1'b0;
            else if (hit && rd_en)          locks[k] <= 1'b1;
            else if (hit && wr_en && !wbit) locks[k] <= 1'b0;
        end
    end

    // R7
    read_takes_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> locks[$past(idx)]);

    // R8
    zero_frees_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wbit) |=> !locks[$past(idx)]);

    // R8
    one_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wbit) |=> $stable(locks));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbox_pkg::*;
#(
    parameter int NUM_ELEM  = 4,
    parameter int NUM_LOCKS = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_ELEM-1:0] irq
);

    localparam int ELEM_IDX_W = $clog2(NUM_ELEM);
    localparam int LOCK_IDX_W = $clog2(NUM_LOCKS);
    localparam int CMD_BASE   = 0;
    localparam int DATA_BASE  = NUM_ELEM;
    localparam int FLAG_ADDR  = 2 * NUM_ELEM;
    localparam int EN_ADDR    = 2 * NUM_ELEM + 1;
    localparam int LOCK_BASE  = 2 ** (ADDR_W - 1);

    reg_kind_e               kind;
    logic [ELEM_IDX_W-1:0]   elem_idx;
    logic [LOCK_IDX_W-1:0]   lock_idx;
    logic                    wr_acc;
    logic                    rd_acc;
    logic [DATA_W-1:0]       cmd_arr  [NUM_ELEM];
    logic [DATA_W-1:0]       data_arr [NUM_ELEM];
    logic [NUM_ELEM-1:0]     flags;
    logic [NUM_ELEM-1:0]     enables;
    logic [NUM_LOCKS-1:0]    locks;
    logic [DATA_W-1:0]       rd_next;

    assign wr_acc   = req_valid &  req_write;
    assign rd_acc   = req_valid & !req_write;
    assign elem_idx = req_addr[ELEM_IDX_W-1:0];
    assign lock_idx = req_addr[LOCK_IDX_W-1:0];

    // address decode
    always_comb begin
        int a;
        a = int'(req_addr);
        if (a >= CMD_BASE && a < CMD_BASE + NUM_ELEM)          kind = RG_CMD;
        else if (a >= DATA_BASE && a < DATA_BASE + NUM_ELEM)   kind = RG_DATA;
        else if (a == FLAG_ADDR)                               kind = RG_FLAG;
        else if (a == EN_ADDR)                                 kind = RG_EN;
        else if (a >= LOCK_BASE && a < LOCK_BASE + NUM_LOCKS)  kind = RG_LOCK;
        else                                                   kind = RG_NONE;
    end

    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_slot
        logic hit;
        assign hit = (elem_idx == ELEM_IDX_W'(i));
        mbox_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_we   (wr_acc && kind == RG_CMD  && hit),
            .data_we  (wr_acc && kind == RG_DATA && hit),
            .en_we    (wr_acc && kind == RG_EN),
            .flag_clr (wr_acc && kind == RG_FLAG && req_wdata[i]),
            .flag_set (wr_acc && kind == RG_FLAG && req_wdata[NUM_ELEM + i]),
            .wdata    (req_wdata),
            .en_wdata (req_wdata[i]),
            .cmd_q    (cmd_arr[i]),
            .data_q   (data_arr[i]),
            .flag_q   (flags[i]),
            .en_q     (enables[i]),
            .irq      (irq[i])
        );
    end

    mbox_lock_bank #(.NUM_LOCKS(NUM_LOCKS)) u_locks (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_acc && kind == RG_LOCK),
        .wr_en (wr_acc && kind == RG_LOCK),
        .idx   (lock_idx),
        .wbit  (req_wdata[0]),
        .locks (locks)
    );

    // read selection, from state before the accepting edge
    always_comb begin
        rd_next = '0;
        unique case (kind)
            RG_CMD:  rd_next = cmd_arr[elem_idx];
            RG_DATA: rd_next = data_arr[elem_idx];
            RG_FLAG: rd_next[NUM_ELEM-1:0] = flags;
            RG_EN:   rd_next[NUM_ELEM-1:0] = enables;
            RG_LOCK: rd_next[0] = locks[lock_idx];
            RG_NONE: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_acc) rd_data <= rd_next;
    end

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(rd_data));

    // R4
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && kind == RG_EN && req_wdata[NUM_ELEM-1:0] == '0) |=> (irq == '0));

    // R7
    lock_read_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && kind == RG_LOCK) |=> (rd_data[DATA_W-1:1] == '0));

endmodule

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [31:0] m_cmd [4];
    logic [31:0] m_data [4];
    logic [3:0]  m_flag = '0;
    logic [3:0]  m_en = '0;
    logic        m_lock [32];
    logic [31:0] m_rd = '0;
    string       cur_tag = "R1";
    string       chk_tag = "R1";

    always #2 clk = ~clk;

    ipc_mailbox uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .irq(irq)
    );

    initial begin
        for (int i = 0; i < 4; i++) begin m_cmd[i] = '0; m_data[i] = '0; end
        for (int k = 0; k < 32; k++) m_lock[k] = 1'b0;
    end

    function automatic logic [31:0] model_read(input int a);
        logic [31:0] v;
        v = '0;
        if (a < 4)                  v = m_cmd[a];
        else if (a < 8)             v = m_data[a-4];
        else if (a == 8)            v[3:0] = m_flag;
        else if (a == 9)            v[3:0] = m_en;
        else if (a >= 32 && a < 64) v[0] = m_lock[a-32];
        return v;
    endfunction

    // model update at the edge
    always @(posedge clk) begin
        if (rst_n && req_valid) begin
            int a;
            a = int'(req_addr);
            chk_tag = cur_tag;
            if (!req_write) begin
                m_rd = model_read(a);
                if (a >= 32) m_lock[a-32] = 1'b1;
            end else begin
                if (a < 4) begin m_cmd[a] = req_wdata; m_flag[a] = 1'b1; end
                else if (a < 8) m_data[a-4] = req_wdata;
                else if (a == 8) m_flag = (m_flag & ~req_wdata[3:0]) | req_wdata[7:4];
                else if (a == 9) m_en = req_wdata[3:0];
                else if (a >= 32 && !req_wdata[0]) m_lock[a-32] = 1'b0;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (rd_data !== m_rd) begin
                miscompares++;
                $display("FAIL %s rd_data got %h expected %h at %0t", chk_tag, rd_data, m_rd, $time);
            end
            if (irq !== (m_flag & m_en)) begin
                miscompares++;
                $display("FAIL %s (R4) irq got %b expected %b at %0t", chk_tag, irq, m_flag & m_en, $time);
            end
        end
    end

    task automatic acc(input logic w, input int a, input logic [31:0] d, input string tag);
        @(negedge clk);
        cur_tag   = tag;
        req_valid = 1'b1;
        req_write = w;
        req_addr  = 6'(a);
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(input int a, input string tag);
        acc(1'b0, a, '0, tag);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        acc(1'b1, a, d, tag);
    endtask

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every register reads zero after reset
        for (int a = 0; a < 10; a++) rd(a, "R1");
        rd(32, "R1"); rd(63, "R1");
        // R9: unmapped addresses
        rd(10, "R9"); rd(31, "R9");
        wr(12, 32'hFFFF_FFFF, "R9"); wr(20, 32'h0000_00FF, "R9");
        for (int a = 0; a < 10; a++) rd(a, "R9");
        // R2: data words, no flag change
        for (int i = 0; i < 4; i++) wr(4+i, 32'hD00D_0000 + i, "R2");
        for (int i = 0; i < 4; i++) rd(4+i, "R2");
        rd(8, "R2");
        // R10: enables
        wr(9, 32'hFFFF_FFF5, "R10"); rd(9, "R10");
        // R3 and R4: command writes raise flags and interrupts
        for (int i = 0; i < 4; i++) wr(i, 32'hC0DE_0000 + i, "R3");
        for (int i = 0; i < 4; i++) rd(i, "R3");
        rd(8, "R3");
        wr(9, 32'h0000_000A, "R4"); wr(9, 32'h0, "R4"); wr(9, 32'hF, "R4");
        // R5: write-one-to-clear
        wr(8, 32'h0000_0003, "R5"); rd(8, "R5");
        wr(8, 32'h0000_0000, "R5"); rd(8, "R5");
        wr(8, 32'h0000_000F, "R5"); rd(8, "R5");
        // R6: software raise, and raise beats clear
        wr(8, 32'h0000_0020, "R6"); rd(8, "R6");
        wr(8, 32'h0000_0011, "R6"); rd(8, "R6");
        wr(8, 32'h0000_00FF, "R6"); rd(8, "R6");
        // R7: test-and-set
        rd(35, "R7"); rd(35, "R7"); rd(32, "R7"); rd(63, "R7");
        // R8: release only on bit 0 equal to zero
        wr(35, 32'h0000_0001, "R8"); rd(35, "R8");
        wr(35, 32'hFFFF_FFFE, "R8"); rd(35, "R8"); rd(35, "R8");
        // mixed pseudo-random traffic over all regions
        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 600; n++) begin
            int a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr[7] ? int'(lfsr[5:0]) : int'(lfsr[3:0]);
            acc(lfsr[9], a, {lfsr[15:0], lfsr[31:16]}, "R9");
        end
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule